// File: doc/BRIEF.md
# Parallel converter read controller

This block sits in an FPGA and runs an external successive-approximation converter with a parallel output bus. It drives an active-low conversion-start strobe, an active-low chip select and an active-low read strobe, and it also drives the converter's clock. It watches the converter's busy flag and captures the 10-bit or 12-bit result word. On the user side a one-cycle start request asks for a conversion. Each finished conversion comes back as a one-cycle valid pulse together with the captured word.

Two converter modes can be used. In the awake mode the start strobe is raised again shortly after it falls, so the converter stays powered. The controller then leaves a set acquisition gap between the end of one conversion and the start of the next. In the sleep mode the strobe is left low through the end of conversion, so the converter powers down. The next request first raises the strobe and waits out a wake-up time before it starts the conversion. A separate burst option stops the converter clock except while a conversion is running.

After reset, one conversion runs on its own so that the converter settles. Its result is thrown away. A conversion that never finishes raises a timeout pulse, and the controller then returns to idle.

Top module: `adc_par_ctrl`

## Requirements
- R1: While rst_ni is low, cnv_n_o, cs_n_o and rd_n_o are high (1), and res_valid_o and timeout_o are low (0).
- R2: After reset a conversion is started without any start_i request. That conversion produces no res_valid_o pulse.
- R3: Each accepted start request gives exactly one res_valid_o pulse, one cycle wide. res_data_o equals the bus word present just before rd_n_o rises. Any number of start_i pulses that arrive while a conversion is in progress are merged into one further conversion.
- R4: In awake mode (sleep_mode_i = 0 when the conversion starts), cnv_n_o is low for exactly CNV_LOW_CYC cycles and is high again before busy falls.
- R5: In awake mode, at least ceil(ACQ_NS/CLK_NS) cycles pass between busy falling and the next falling edge of cnv_n_o.
- R6: In sleep mode (sleep_mode_i = 1 when the conversion starts), cnv_n_o stays low through the fall of busy. If the converter is asleep, the next conversion first drives cnv_n_o high for at least ceil(WAKE_NS/CLK_NS) cycles before driving it low.
- R7: cs_n_o and rd_n_o are never low while busy_i is high. They go low only after the conversion ends, and rd_n_o stays low for RD_CYC cycles.
- R8: With burst_i = 1, cclk_o is held low while no conversion is running. It gives its first rising edge no more than two cycles after cnv_n_o falls, and it keeps running until busy has fallen and at least DW+2 rising edges have been delivered.
- R9: With burst_i = 0, cclk_o toggles on every clock cycle, which is half the system clock rate.
- R10: If a conversion does not end within TIMEOUT_CYC cycles of cnv_n_o falling, timeout_o pulses for one cycle and no result is reported. The controller then accepts the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle conversion request |
| sleep_mode_i | input | 1 | 1 = converter sleeps after each conversion; sampled when a conversion starts |
| burst_i | input | 1 | 1 = converter clock runs only during a conversion |
| busy_i | input | 1 | Converter busy flag (asynchronous) |
| data_i | input | DW | Converter parallel data bus |
| cnv_n_o | output | 1 | Active-low conversion start strobe |
| cs_n_o | output | 1 | Active-low chip select |
| rd_n_o | output | 1 | Active-low read strobe |
| cclk_o | output | 1 | Converter clock |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | DW | Captured conversion result |
| timeout_o | output | 1 | One-cycle conversion-timeout pulse |

## Verification
The request latch and the conversion sequence can act in the same window. A start request may arrive while a conversion or its read is still in progress, and it must then give exactly one further conversion: it must be neither lost nor repeated. The bench provokes this by sending several start pulses while the converter model's busy flag is high. It judges the outcome by counting exactly two results, each carrying the word the model produced for that conversion. The sweep covers every combination of sleep and burst, and a converter model checks the acquisition time, the wake-up time, the clock start window and any read during busy on every conversion.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAKE,
    ST_CONV,
    ST_READ
  } seq_st_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else begin
      sr_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/adc_cclk_gen.sv
module adc_cclk_gen #(
  parameter int MIN_EDGES = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic start_i,
  input  logic hold_i,
  output logic cclk_o
);
  localparam int EW = $clog2(MIN_EDGES + 1);

  logic [EW-1:0] edge_cnt_q;
  logic          cclk_q;
  logic          short_w;
  logic          run_w;

  assign short_w = edge_cnt_q < EW'(MIN_EDGES);
  // finish a high phase before parking the clock low
  assign run_w   = !gate_i || hold_i || short_w || cclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cclk_q     <= 1'b0;
      edge_cnt_q <= EW'(MIN_EDGES);
    end else begin
      cclk_q <= run_w ? ~cclk_q : 1'b0;
      if (start_i) edge_cnt_q <= '0;
      else if (run_w && !cclk_q && short_w) edge_cnt_q <= edge_cnt_q + 1'b1;
    end
  end

  assign cclk_o = cclk_q;

  a_r8_edge_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_cnt_q <= EW'(MIN_EDGES));

  a_r8_no_gap_mid_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && !start_i && $past(hold_i) |-> cclk_q != $past(cclk_q));
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_ctrl_pkg::*;
#(
  parameter int ACQ_CYC     = 14,
  parameter int WAKE_CYC    = 100,
  parameter int CNV_LOW_CYC = 2,
  parameter int RD_CYC      = 2,
  parameter int TIMEOUT_CYC = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sleep_mode_i,
  input  logic busy_s_i,
  output logic cnv_n_o,
  output logic cs_n_o,
  output logic rd_n_o,
  output logic go_o,
  output logic act_o,
  output logic cap_o,
  output logic dummy_o,
  output logic timeout_o
);
  localparam int CMAX = max2(max2(TIMEOUT_CYC, WAKE_CYC), max2(CNV_LOW_CYC, RD_CYC));
  localparam int CW   = $clog2(CMAX + 1);
  localparam int GW   = $clog2(ACQ_CYC + 1);

  seq_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic [GW-1:0] guard_q;
  logic req_q, dum_pend_q, dum_cur_q, sleep_q, seen_q;
  logic cnv_n_q, cs_n_q, rd_n_q, act_q, to_q;
  logic launch_w, done_w, to_hit_w, cap_w;

  assign launch_w = (st_q == ST_IDLE) && (req_q || dum_pend_q) && (guard_q == '0);
  assign done_w   = (st_q == ST_CONV) && seen_q && !busy_s_i;
  assign to_hit_w = (st_q == ST_CONV) && !done_w && (cnt_q == CW'(TIMEOUT_CYC - 1));
  assign cap_w    = (st_q == ST_READ) && (cnt_q == CW'(RD_CYC - 1));
  assign go_o     = (launch_w && cnv_n_q) || ((st_q == ST_WAKE) && (cnt_q == CW'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      guard_q    <= GW'(ACQ_CYC);
      req_q      <= 1'b0;
      dum_pend_q <= 1'b1;
      dum_cur_q  <= 1'b0;
      sleep_q    <= 1'b0;
      seen_q     <= 1'b0;
      cnv_n_q    <= 1'b1;
      cs_n_q     <= 1'b1;
      rd_n_q     <= 1'b1;
      act_q      <= 1'b0;
      to_q       <= 1'b0;
    end else begin
      to_q <= to_hit_w;
      if (start_i) req_q <= 1'b1;
      else if (launch_w) req_q <= 1'b0;
      if (guard_q != '0) guard_q <= guard_q - 1'b1;

      unique case (st_q)
        ST_IDLE: begin
          if (launch_w) begin
            dum_pend_q <= 1'b0;
            dum_cur_q  <= dum_pend_q;
            sleep_q    <= sleep_mode_i;
            seen_q     <= 1'b0;
            if (cnv_n_q) begin
              st_q    <= ST_CONV;
              cnv_n_q <= 1'b0;
              act_q   <= 1'b1;
              cnt_q   <= '0;
            end else begin
              // converter asleep: raise strobe to wake it first
              st_q    <= ST_WAKE;
              cnv_n_q <= 1'b1;
              cnt_q   <= CW'(WAKE_CYC);
            end
          end
        end
        ST_WAKE: begin
          if (cnt_q == CW'(1)) begin
            st_q    <= ST_CONV;
            cnv_n_q <= 1'b0;
            act_q   <= 1'b1;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_CONV: begin
          cnt_q <= cnt_q + 1'b1;
          if (busy_s_i) seen_q <= 1'b1;
          if (!sleep_q && cnt_q == CW'(CNV_LOW_CYC - 1)) cnv_n_q <= 1'b1;
          if (done_w) begin
            st_q    <= ST_READ;
            cnt_q   <= '0;
            cs_n_q  <= 1'b0;
            rd_n_q  <= 1'b0;
            act_q   <= 1'b0;
            guard_q <= GW'(ACQ_CYC);
          end else if (to_hit_w) begin
            st_q    <= ST_IDLE;
            cnv_n_q <= 1'b1;
            act_q   <= 1'b0;
            guard_q <= GW'(ACQ_CYC);
          end
        end
        ST_READ: begin
          cnt_q <= cnt_q + 1'b1;
          if (cap_w) begin
            cs_n_q <= 1'b1;
            rd_n_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_n_o   = cnv_n_q;
  assign cs_n_o    = cs_n_q;
  assign rd_n_o    = rd_n_q;
  assign act_o     = act_q;
  assign cap_o     = cap_w;
  assign dummy_o   = dum_cur_q;
  assign timeout_o = to_q;

  a_r7_no_read_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_q || !cs_n_q |-> !busy_s_i);

  a_r4_raise_before_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_w && !sleep_q |-> cnv_n_q);

  a_r6_hold_through_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_w && sleep_q |-> !cnv_n_q);

  a_r5_acq_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnv_n_q) |-> guard_q == '0);

  a_r10_timeout_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_q |=> !to_q);
endmodule

// File: rtl/adc_par_ctrl.sv
module adc_par_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int DW          = 12,
  parameter int CLK_NS      = 10,
  parameter int ACQ_NS      = 135,
  parameter int WAKE_NS     = 1000,
  parameter int CNV_LOW_CYC = 2,
  parameter int RD_CYC      = 2,
  parameter int TIMEOUT_CYC = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          sleep_mode_i,
  input  logic          burst_i,
  input  logic          busy_i,
  input  logic [DW-1:0] data_i,
  output logic          cnv_n_o,
  output logic          cs_n_o,
  output logic          rd_n_o,
  output logic          cclk_o,
  output logic          res_valid_o,
  output logic [DW-1:0] res_data_o,
  output logic          timeout_o
);
  localparam int ACQ_CYC   = ns_to_cyc(ACQ_NS, CLK_NS);
  localparam int WAKE_CYC  = max2(ns_to_cyc(WAKE_NS, CLK_NS), 1);
  localparam int MIN_EDGES = DW + 2;

  logic busy_s, go, act, cap, dummy;
  logic          valid_q;
  logic [DW-1:0] data_q;

  adc_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (busy_i),
    .q_o   (busy_s)
  );

  adc_seq #(
    .ACQ_CYC    (ACQ_CYC),
    .WAKE_CYC   (WAKE_CYC),
    .CNV_LOW_CYC(CNV_LOW_CYC),
    .RD_CYC     (RD_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .sleep_mode_i(sleep_mode_i),
    .busy_s_i    (busy_s),
    .cnv_n_o     (cnv_n_o),
    .cs_n_o      (cs_n_o),
    .rd_n_o      (rd_n_o),
    .go_o        (go),
    .act_o       (act),
    .cap_o       (cap),
    .dummy_o     (dummy),
    .timeout_o   (timeout_o)
  );

  adc_cclk_gen #(.MIN_EDGES(MIN_EDGES)) u_cclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (burst_i),
    .start_i(go),
    .hold_i (act),
    .cclk_o (cclk_o)
  );

  // capture on the edge where rd_n rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= cap && !dummy;
      if (cap) data_q <= data_i;
    end
  end

  assign res_valid_o = valid_q;
  assign res_data_o  = data_q;

  a_r3_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  a_r8_burst_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_i && $fell(cnv_n_o) && !cclk_o |=> cclk_o);

  a_r3_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $rose(rd_n_o));
endmodule

// File: tb/adc_par_ctrl_tb.sv
module adc_par_ctrl_tb;
  localparam int DW       = 12;
  localparam int CLK_NS   = 10;
  localparam int ACQ_NS   = 135;
  localparam int WAKE_NS  = 400;
  localparam int CNV_LOW  = 2;
  localparam int RD_CYC   = 2;
  localparam int TO_CYC   = 120;
  localparam int ACQ_CYC  = (ACQ_NS + CLK_NS - 1) / CLK_NS;
  localparam int WAKE_CYC = (WAKE_NS + CLK_NS - 1) / CLK_NS;
  localparam int N_EDGES  = DW + 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sleep_mode = 1'b0, burst = 1'b0, busy = 1'b0;
  logic [DW-1:0] data;
  logic cnv_n, cs_n, rd_n, cclk, valid, tmo;
  logic [DW-1:0] res;

  always #5 clk = ~clk;

  adc_par_ctrl #(
    .DW(DW), .CLK_NS(CLK_NS), .ACQ_NS(ACQ_NS), .WAKE_NS(WAKE_NS),
    .CNV_LOW_CYC(CNV_LOW), .RD_CYC(RD_CYC), .TIMEOUT_CYC(TO_CYC), .SYNC_STAGES(2)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sleep_mode_i(sleep_mode),
    .burst_i(burst), .busy_i(busy), .data_i(data), .cnv_n_o(cnv_n), .cs_n_o(cs_n),
    .rd_n_o(rd_n), .cclk_o(cclk), .res_valid_o(valid), .res_data_o(res), .timeout_o(tmo)
  );

  int checks = 0, fails = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] word_of(input int n);
    return DW'((n * 1657 + 291) % (1 << DW));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model
  logic [DW-1:0] mdl_res = '0;
  int mdl_n = 0, edges = 0;
  logic cnv_p = 1'b1, cclk_p = 1'b0, asleep = 1'b0, waking = 1'b0, first_seen = 1'b0, stuck = 1'b0;
  longint rise_c = 0, fall_c = 0, bfall_c = -1000;
  int v_acq = 0, v_wake = 0, v_win = 0, v_hs = 0, v_sl = 0, v_rd = 0, v_free = 0;

  assign data = (!cs_n && !rd_n) ? mdl_res : '0;

  always @(posedge clk) begin
    cnv_p  <= cnv_n;
    cclk_p <= cclk;
    if (rst_n) begin
      if (cnv_n && !cnv_p && asleep) begin
        asleep <= 1'b0; waking <= 1'b1; rise_c <= cyc;
      end
      if (!cnv_n && cnv_p && !stuck) begin
        if (asleep) v_wake++;
        else if (waking && (cyc - rise_c) < WAKE_CYC) v_wake++;
        if (!waking && !asleep && (cyc - bfall_c) < ACQ_CYC) v_acq++;
        waking <= 1'b0; busy <= 1'b1; edges <= 0; fall_c <= cyc; first_seen <= 1'b0;
      end else if (busy && cclk && !cclk_p) begin
        if (!first_seen && burst && (cyc - fall_c) > 2) v_win++;
        first_seen <= 1'b1;
        if (edges == N_EDGES - 1) begin
          busy <= 1'b0; mdl_res <= word_of(mdl_n); mdl_n <= mdl_n + 1; bfall_c <= cyc;
          if (sleep_mode) begin
            if (cnv_n) v_sl++; else asleep <= 1'b1;
          end else if (!cnv_n) v_hs++;
        end else edges <= edges + 1;
      end
    end
  end

  // port monitors, sampled at the falling edge
  int vcnt = 0, tocnt = 0;
  logic valid_p = 1'b0, cnv_np = 1'b1, rd_np = 1'b1;
  logic [2:0] bhist = 3'b111;
  logic cclk_np = 1'b0;
  longint mfall = 0, mrise = 0, rdfall = 0, low_w = 0, high_w = 0, rd_w = 0, to_delay = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        vcnt++;
        chk(res == word_of(mdl_n - 1), "R3 result word", res, word_of(mdl_n - 1));
      end
      if (valid && valid_p) chk(1'b0, "R3 valid width", 2, 1);
      if (tmo) begin tocnt++; to_delay = cyc - mfall; end
      if (busy && (!cs_n || !rd_n)) v_rd++;
      if (!cnv_n && cnv_np) begin high_w = cyc - mrise; mfall = cyc; end
      if (cnv_n && !cnv_np) begin low_w = cyc - mfall; mrise = cyc; end
      if (!rd_n && rd_np) rdfall = cyc;
      if (rd_n && !rd_np) rd_w = cyc - rdfall;
      bhist = {bhist[1:0], burst};
      if (bhist == 3'b000 && cclk == cclk_np) v_free++;
    end
    valid_p = valid; cnv_np = cnv_n; rd_np = rd_n; cclk_np = cclk;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_results(input int n, input int limit);
    int base = vcnt;
    for (int i = 0; i < limit && vcnt < base + n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    finish_run();
  end

  initial begin
    int v0, t0, lowbad;
    repeat (3) @(negedge clk);
    chk(cnv_n == 1'b1, "R1 cnv_n in reset", cnv_n, 1);
    chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
    chk(rd_n == 1'b1, "R1 rd_n in reset", rd_n, 1);
    chk(valid == 1'b0, "R1 valid in reset", valid, 0);
    chk(tmo == 1'b0, "R1 timeout in reset", tmo, 0);
    rst_n = 1'b1;

    repeat (200) @(negedge clk);
    chk(mdl_n == 1, "R2 dummy conversion ran", mdl_n, 1);
    chk(vcnt == 0, "R2 dummy result hidden", vcnt, 0);

    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 2; b++) begin
        sleep_mode = m[0]; burst = b[0];
        repeat (4) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
          v0 = vcnt;
          pulse_start();
          wait_results(1, 1000);
          chk(vcnt == v0 + 1, "R3 one result per request", vcnt, v0 + 1);
          chk(rd_w == RD_CYC, "R7 read strobe width", rd_w, RD_CYC);
          if (m == 0) chk(low_w == CNV_LOW, "R4 start strobe width", low_w, CNV_LOW);
          if (m == 1 && (k > 0 || b > 0))
            chk(high_w >= WAKE_CYC && high_w <= WAKE_CYC + 1, "R6 wake interval", high_w, WAKE_CYC);
          if (b == 1) begin
            repeat (10) @(negedge clk);
            lowbad = 0;
            for (int i = 0; i < 20; i++) begin
              if (cclk) lowbad++;
              @(negedge clk);
            end
            chk(lowbad == 0, "R8 clock parked low when idle", lowbad, 0);
          end
        end
        if (m == 1) chk(asleep == 1'b1, "R6 converter left asleep", asleep, 1);
      end
    end

    // requests merged while a conversion runs
    sleep_mode = 1'b0; burst = 1'b0;
    repeat (4) @(negedge clk);
    v0 = vcnt;
    pulse_start();
    for (int i = 0; i < 100 && !busy; i++) @(negedge clk);
    pulse_start(); pulse_start(); pulse_start();
    wait_results(2, 2000);
    repeat (300) @(negedge clk);
    chk(vcnt == v0 + 2, "R3 merged requests", vcnt, v0 + 2);

    // timeout
    stuck = 1'b1; t0 = tocnt; v0 = vcnt;
    pulse_start();
    repeat (2 * TO_CYC + 20) @(negedge clk);
    chk(tocnt == t0 + 1, "R10 one timeout pulse", tocnt, t0 + 1);
    chk(vcnt == v0, "R10 no result on timeout", vcnt, v0);
    chk(to_delay >= TO_CYC - 1 && to_delay <= TO_CYC + 1, "R10 timeout delay", to_delay, TO_CYC);
    stuck = 1'b0;
    pulse_start();
    wait_results(1, 1000);
    chk(vcnt == v0 + 1, "R10 recovery after timeout", vcnt, v0 + 1);

    repeat (50) @(negedge clk);
    chk(v_hs == 0, "R4 strobe high at end of conversion", v_hs, 0);
    chk(v_acq == 0, "R5 acquisition gap", v_acq, 0);
    chk(v_wake == 0, "R6 wake-up respected", v_wake, 0);
    chk(v_sl == 0, "R6 strobe low at end of conversion", v_sl, 0);
    chk(v_rd == 0, "R7 no read while busy", v_rd, 0);
    chk(v_win == 0, "R8 clock start window", v_win, 0);
    chk(v_free == 0, "R9 free-running clock", v_free, 0);
    finish_run();
  end
endmodule